// File: doc/BRIEF.md
# Debug Port Serial Shift Interface

This block is the serial access path between an external debug host and a CPU. A single 35-bit shift register does three jobs. It holds instruction words that the host shifts in for the CPU to fetch. It holds data words that move between host and CPU in either direction. It also stages the value for a 9-bit trap enable control register. Each word is led by a 3-bit tag and followed by a 32-bit payload. The control register drives six trap enable lines, two breakpoint lines and one sync line towards the CPU.

The host presents one bit per shift tick on `serIn` and reads the bit leaving on `serOut`. A tick comes from one of two sources, picked by `clkSel`. One source is the rising edge of a dedicated debug clock, resynchronised into the system clock domain. The other is every system clock cycle. In both cases ticks happen only while `serEn` is high. When a full word has arrived, its tag decides what happens next. A word tagged as a control transfer updates the control register. Any other word raises a ready flag so that the CPU can read it in parallel. The CPU can also parallel-load a data word, which the host then shifts out. A registered 2-bit freeze status tells the host whether the CPU is halted.

Top module: `dbg_shift_port`

## Requirements
- R1: After reset, the shift register, the bit counter, the control register, the ready flag and the freeze status are all zero. As a result `serOut`, `wordReady`, `trapEn`, `brkOut`, `syncOut` and `frzStatus` read 0.
- R2: Shifting is MSB-first. Before each tick, `serOut` shows bit 34 of the shift register. On a tick, the register moves up by one place and `serIn` enters bit 0. After 35 ticks the register holds the 35 bits in the order they were sent.
- R3: With `clkSel`=1, every system clock cycle in which `serEn` is high is a tick. With `clkSel`=0, each rising edge of `dbgClk` while `serEn` is high is one tick. Edges of `dbgClk` while `serEn` is low do not shift.
- R4: When the 35th tick completes a word whose top 3 bits are not 3'b111, `wordReady` rises in the next cycle. At the same time, `cpuRdData` shows bits 31:0 of the word and `wordTag` shows bits 34:32.
- R5: When the 35th tick completes a word whose top 3 bits are 3'b111, bits 8:0 of the word load the control register, and `wordReady` is 0 in the next cycle. The control register drives the outputs as follows: `trapEn` = bits 5:0, `brkOut` = bits 7:6, `syncOut` = bit 8.
- R6: The control register changes only on a completed control-transfer word. Instruction words, data words, partial words and CPU loads leave it unchanged.
- R7: A cycle with `cpuRdEn` high and no word completing clears `wordReady`.
- R8: `cpuWrEn` loads the shift register with {3'b001, `cpuWrData`}, clears `wordReady` and restarts the bit count. The next 35 ticks then put this word on `serOut`, MSB first.
- R9: If `cpuWrEn` falls in the same cycle as a tick, the load wins and the tick is dropped. This holds even for the tick that would have completed a word: no control load takes place and no ready flag is set.
- R10: If a word completes in the same cycle as `cpuRdEn`, the completion wins: `wordReady` stays high for the new word.
- R11: `frzStatus` is 2'b11 in the cycle after `freezeIn` is high, and 2'b00 in the cycle after it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 1 | Tick source: 1 = system clock, 0 = debug clock edges |
| dbgClk | input | 1 | Dedicated debug shift clock (asynchronous) |
| serEn | input | 1 | Enables shift ticks |
| serIn | input | 1 | Serial data from host |
| serOut | output | 1 | Serial data to host (shift register MSB) |
| cpuRdEn | input | 1 | CPU reads the shifted-in word |
| cpuRdData | output | 32 | Payload of the shifted word |
| wordTag | output | 3 | Tag of the shifted word |
| wordReady | output | 1 | A complete non-control word is waiting |
| cpuWrEn | input | 1 | CPU parallel-loads a data word |
| cpuWrData | input | 32 | Data word to load |
| trapEn | output | 6 | Trap enable lines |
| brkOut | output | 2 | Breakpoint lines |
| syncOut | output | 1 | Sync line |
| freezeIn | input | 1 | CPU halted indication |
| frzStatus | output | 2 | Freeze status to host |

## Verification
Two collisions are provoked on purpose. In the first, a CPU parallel load is placed in the same cycle as the final tick of a control-transfer word. The check is that the control outputs keep their old value, that the ready flag is low, and that the next 35 bits shifted out are exactly the loaded word. In the second, a CPU read is placed on the final tick of a new instruction word while an older word is still flagged. The check is that the ready flag stays high and that the new payload is presented. A full sweep of all 512 control values also checks the 3-way split of the control register, and it checks the previous word as it streams out on the serial output.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic wordDone;
    logic ctrlLd;
  } portStrb_t;

endpackage

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
  import dbg_port_pkg::*;
#(
  parameter int WORD_W      = 35,
  parameter int TAG_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [TAG_W-1:0] CTRL_TAG = 3'b111
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkSel,
  input  logic             dbgClk,
  input  logic             serEn,
  input  logic             cpuWrEn,
  input  logic             cpuRdEn,
  input  logic [TAG_W-1:0] nextTag,
  input  logic             freezeIn,
  output portStrb_t        strb,
  output logic             wordReady,
  output logic [1:0]       frzStatus
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES:0] dbgPipe;
  logic                 dbgRise;
  logic                 tick;
  logic [CNT_W-1:0]     bitCnt;
  logic                 lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) dbgPipe <= '0;
    else       dbgPipe <= {dbgPipe[SYNC_STAGES-1:0], dbgClk};
  end

  assign dbgRise = dbgPipe[SYNC_STAGES-1] & ~dbgPipe[SYNC_STAGES];

  always_comb begin
    tick = 1'b0;
    if (serEn) tick = clkSel ? 1'b1 : dbgRise;
  end

  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    strb          = '0;
    strb.loadEn   = cpuWrEn;
    strb.shiftEn  = tick & ~cpuWrEn;
    strb.wordDone = strb.shiftEn & lastBit;
    strb.ctrlLd   = strb.wordDone & (nextTag == CTRL_TAG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.loadEn || strb.wordDone) begin
      bitCnt <= '0;
    end else if (strb.shiftEn) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReady <= 1'b0;
    end else if (strb.loadEn) begin
      wordReady <= 1'b0;
    end else if (strb.wordDone) begin
      wordReady <= ~strb.ctrlLd;
    end else if (cpuRdEn) begin
      wordReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frzStatus <= 2'b00;
    else       frzStatus <= freezeIn ? 2'b11 : 2'b00;
  end

  // R7
  rd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && !strb.wordDone) |=> !wordReady);

  // R8
  load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> (!wordReady && bitCnt == '0));

  // R9
  load_beats_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |-> !strb.shiftEn);

  // R10
  done_beats_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordDone && !strb.ctrlLd) |=> wordReady);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  // R11
  frz_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    freezeIn |=> frzStatus == 2'b11);

endmodule

// File: rtl/dbg_port_dpath.sv
module dbg_port_dpath
  import dbg_port_pkg::*;
#(
  parameter int WORD_W = 35,
  parameter int TAG_W  = 3,
  parameter int CTRL_W = 9,
  parameter logic [TAG_W-1:0] DATA_TAG = 3'b001
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  portStrb_t               strb,
  input  logic                    serIn,
  input  logic [WORD_W-TAG_W-1:0] cpuWrData,
  output logic                    serOut,
  output logic [WORD_W-TAG_W-1:0] cpuRdData,
  output logic [TAG_W-1:0]        wordTag,
  output logic [TAG_W-1:0]        nextTag,
  output logic [CTRL_W-1:0]       ctrlBits
);

  localparam int PAY_W = WORD_W - TAG_W;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;
  logic [CTRL_W-1:0] ctrlReg;

  assign shiftNext = {shiftReg[WORD_W-2:0], serIn};
  assign nextTag   = shiftNext[WORD_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.loadEn) begin
      shiftReg <= {DATA_TAG, cpuWrData};
    end else if (strb.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strb.ctrlLd) begin
      ctrlReg <= shiftNext[CTRL_W-1:0];
    end
  end

  assign serOut    = shiftReg[WORD_W-1];
  assign cpuRdData = shiftReg[PAY_W-1:0];
  assign wordTag   = shiftReg[WORD_W-1 -: TAG_W];
  assign ctrlBits  = ctrlReg;

  // R2
  lsb_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> shiftReg[0] == $past(serIn));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlLd |=> $stable(ctrlReg));

  // R8
  load_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> shiftReg == {DATA_TAG, $past(cpuWrData)});

endmodule

// File: rtl/dbg_shift_port.sv
module dbg_shift_port
  import dbg_port_pkg::*;
#(
  parameter int WORD_W      = 35,
  parameter int TAG_W       = 3,
  parameter int TRAP_N      = 6,
  parameter int BRK_N       = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [TAG_W-1:0] CTRL_TAG = 3'b111,
  parameter logic [TAG_W-1:0] DATA_TAG = 3'b001
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkSel,
  input  logic                    dbgClk,
  input  logic                    serEn,
  input  logic                    serIn,
  output logic                    serOut,
  input  logic                    cpuRdEn,
  output logic [WORD_W-TAG_W-1:0] cpuRdData,
  output logic [TAG_W-1:0]        wordTag,
  output logic                    wordReady,
  input  logic                    cpuWrEn,
  input  logic [WORD_W-TAG_W-1:0] cpuWrData,
  output logic [TRAP_N-1:0]       trapEn,
  output logic [BRK_N-1:0]        brkOut,
  output logic                    syncOut,
  input  logic                    freezeIn,
  output logic [1:0]              frzStatus
);

  localparam int CTRL_W = TRAP_N + BRK_N + 1;

  portStrb_t         strb;
  logic [TAG_W-1:0]  nextTag;
  logic [CTRL_W-1:0] ctrlBits;

  dbg_port_ctrl #(
    .WORD_W(WORD_W), .TAG_W(TAG_W), .SYNC_STAGES(SYNC_STAGES), .CTRL_TAG(CTRL_TAG)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .dbgClk(dbgClk), .serEn(serEn),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .nextTag(nextTag), .freezeIn(freezeIn),
    .strb(strb), .wordReady(wordReady), .frzStatus(frzStatus)
  );

  dbg_port_dpath #(
    .WORD_W(WORD_W), .TAG_W(TAG_W), .CTRL_W(CTRL_W), .DATA_TAG(DATA_TAG)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn(serIn), .cpuWrData(cpuWrData),
    .serOut(serOut), .cpuRdData(cpuRdData), .wordTag(wordTag), .nextTag(nextTag),
    .ctrlBits(ctrlBits)
  );

  for (genvar t = 0; t < TRAP_N; t++) begin : g_trap
    assign trapEn[t] = ctrlBits[t];
  end
  for (genvar b = 0; b < BRK_N; b++) begin : g_brk
    assign brkOut[b] = ctrlBits[TRAP_N + b];
  end
  assign syncOut = ctrlBits[CTRL_W-1];

endmodule

// File: tb/dbg_shift_port_tb.sv
module dbg_shift_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkSel = 1'b1;
  logic        dbgClk = 1'b0;
  logic        serEn = 1'b0;
  logic        serIn = 1'b0;
  logic        serOut;
  logic        cpuRdEn = 1'b0;
  logic [31:0] cpuRdData;
  logic [2:0]  wordTag;
  logic        wordReady;
  logic        cpuWrEn = 1'b0;
  logic [31:0] cpuWrData = '0;
  logic [5:0]  trapEn;
  logic [1:0]  brkOut;
  logic        syncOut;
  logic        freezeIn = 1'b0;
  logic [1:0]  frzStatus;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_shift_port dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .dbgClk(dbgClk), .serEn(serEn),
    .serIn(serIn), .serOut(serOut), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData),
    .wordTag(wordTag), .wordReady(wordReady), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .trapEn(trapEn), .brkOut(brkOut), .syncOut(syncOut), .freezeIn(freezeIn),
    .frzStatus(frzStatus)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkCtrl(input logic [8:0] v, input string req);
    chk({syncOut, brkOut, trapEn} == v, req, {syncOut, brkOut, trapEn}, v);
  endtask

  // Shift n bits of w, MSB first; record serOut before each tick.
  task automatic shiftWord(input logic [34:0] w, input bit useDbg, input int n,
                           input bit rdLast, input bit wrLast, input logic [31:0] wrData,
                           output logic [34:0] outBits);
    outBits = '0;
    clkSel = ~useDbg;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      serIn = w[34-i];
      serEn = 1'b1;
      outBits = {outBits[33:0], serOut};
      if (!useDbg && i == n-1) begin
        cpuRdEn = rdLast;
        cpuWrEn = wrLast;
        cpuWrData = wrData;
      end
      if (useDbg) begin
        dbgClk = 1'b1;
        repeat (4) @(negedge clk);
        dbgClk = 1'b0;
        repeat (3) @(negedge clk);
      end
    end
    @(negedge clk);
    serEn = 1'b0;
    cpuRdEn = 1'b0;
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuLoad(input logic [31:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1;
    cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead();
    @(negedge clk);
    cpuRdEn = 1'b1;
    @(negedge clk);
    cpuRdEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [34:0] prev, cur, got;
    logic [8:0]  ctrlNow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(serOut == 0 && wordReady == 0, "R1", {serOut, wordReady}, 0);
    chkCtrl(9'h0, "R1");
    chk(frzStatus == 2'b00, "R1", frzStatus, 0);

    // R5/R2: sweep every control value, check the previous word streams out
    prev = '0;
    for (int v = 0; v < 512; v++) begin
      cur = {3'b111, 23'(v * 7 + 3), 9'(v)};
      shiftWord(cur, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
      chkCtrl(9'(v), "R5");
      chk(wordReady == 0, "R5", wordReady, 0);
      chk(got == prev, "R2", got, prev);
      prev = cur;
    end
    ctrlNow = 9'h1FF;

    // R4/R6/R7: instruction/data words, system clock ticks
    for (int k = 0; k < 6; k++) begin
      cur = {3'(k == 5 ? 6 : k), 32'hA5C3_0F01 ^ (32'h1111_1111 * k)};
      shiftWord(cur, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
      chk(wordReady == 1, "R4", wordReady, 1);
      chk(cpuRdData == cur[31:0], "R4", cpuRdData, cur[31:0]);
      chk(wordTag == cur[34:32], "R4", wordTag, cur[34:32]);
      chkCtrl(ctrlNow, "R6");
      chk(got == prev, "R2", got, prev);
      prev = cur;
      cpuRead();
      chk(wordReady == 0, "R7", wordReady, 0);
    end

    // R3: debug clock ticks
    for (int k = 0; k < 3; k++) begin
      cur = {3'b010, 32'h8000_0001 + 32'h0102_0304 * k};
      shiftWord(cur, 1'b1, 35, 1'b0, 1'b0, 32'h0, got);
      chk(wordReady == 1 && cpuRdData == cur[31:0], "R3", {wordReady, cpuRdData}, {1'b1, cur[31:0]});
      chk(got == prev, "R3", got, prev);
      prev = cur;
    end
    // R3: control word through debug clock
    shiftWord({3'b111, 23'h0, 9'h0A5}, 1'b1, 35, 1'b0, 1'b0, 32'h0, got);
    ctrlNow = 9'h0A5;
    chkCtrl(ctrlNow, "R3");

    // R8: parallel load clears ready and is shifted out
    shiftWord({3'b000, 32'h1234_5678}, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
    chk(wordReady == 1, "R4", wordReady, 1);
    cpuLoad(32'hDEAD_BEEF);
    chk(wordReady == 0, "R8", wordReady, 0);
    shiftWord(35'h0, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
    chk(got == {3'b001, 32'hDEAD_BEEF}, "R8", got, {3'b001, 32'hDEAD_BEEF});
    chkCtrl(ctrlNow, "R6");
    cpuRead();
    // R8: partial word then load restarts count
    shiftWord(35'h7_FFFF_FFFF, 1'b0, 10, 1'b0, 1'b0, 32'h0, got);
    cpuLoad(32'h0F0F_3C3C);
    shiftWord({3'b111, 23'h0, 9'h155}, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
    chk(got == {3'b001, 32'h0F0F_3C3C}, "R8", got, {3'b001, 32'h0F0F_3C3C});
    ctrlNow = 9'h155;
    chkCtrl(ctrlNow, "R5");
    // R8 in debug clock mode
    cpuLoad(32'h6BAD_F00D);
    shiftWord(35'h0, 1'b1, 35, 1'b0, 1'b0, 32'h0, got);
    chk(got == {3'b001, 32'h6BAD_F00D}, "R8", got, {3'b001, 32'h6BAD_F00D});

    // R3: debug clock edges ignored while serEn is low
    cpuLoad(32'hC001_D00D);
    clkSel = 1'b0;
    serIn = 1'b1;
    for (int e = 0; e < 8; e++) begin
      @(negedge clk); dbgClk = 1'b1;
      repeat (4) @(negedge clk); dbgClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    shiftWord(35'h0, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
    chk(got == {3'b001, 32'hC001_D00D}, "R3", got, {3'b001, 32'hC001_D00D});

    // R9: load on the final tick of a control word
    shiftWord({3'b111, 23'h0, 9'h0C3}, 1'b0, 35, 1'b0, 1'b1, 32'h5555_AAAA, got);
    chkCtrl(ctrlNow, "R9");
    chk(wordReady == 0, "R9", wordReady, 0);
    shiftWord(35'h0, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
    chk(got == {3'b001, 32'h5555_AAAA}, "R9", got, {3'b001, 32'h5555_AAAA});
    cpuRead();

    // R10: read on the final tick of a new word while an older one is flagged
    shiftWord({3'b000, 32'h0BAD_CAFE}, 1'b0, 35, 1'b0, 1'b0, 32'h0, got);
    shiftWord({3'b011, 32'h7777_1234}, 1'b0, 35, 1'b1, 1'b0, 32'h0, got);
    chk(wordReady == 1, "R10", wordReady, 1);
    chk(cpuRdData == 32'h7777_1234, "R10", cpuRdData, 32'h7777_1234);
    cpuRead();
    chk(wordReady == 0, "R7", wordReady, 0);

    // R11 freeze status
    @(negedge clk); freezeIn = 1'b1;
    @(negedge clk);
    chk(frzStatus == 2'b11, "R11", frzStatus, 2'b11);
    freezeIn = 1'b0;
    @(negedge clk);
    chk(frzStatus == 2'b00, "R11", frzStatus, 2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule